// File: doc/BRIEF.md
# Mode-Selectable Serial Baud Tick Generator

This block produces the bit-rate timing strobe for a serial port. A free-running two-stage timer divides the system clock first by a fixed prescale and then by a programmable 8-bit divisor plus one. Each time the full period runs out, the block raises a one-cycle tick. The prescale follows the port's operating mode. Asynchronous operation uses 64, or 16 when the high-speed bit is set. Synchronous operation uses 4, and the high-speed bit then has no effect.

Software-side logic programs the divisor through a direct write port: an 8-bit data word and a one-cycle strobe. Every divisor write clears both timer stages at once, so a new rate starts from a clean period instead of waiting for the old one to finish. The mode and high-speed inputs are plain levels. Changing them alone does not restart anything: the prescale stage picks up the new length at its next wrap.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the stored divisor is 0 and `baud_tick` is low. With asynchronous mode and the high-speed bit clear, the first tick comes 64 clock edges after reset is released.
- R2: With `sync_mode`=0 and `high_speed`=0, ticks are spaced 64×(n+1) cycles apart, where n is the stored divisor.
- R3: With `sync_mode`=0 and `high_speed`=1, ticks are spaced 16×(n+1) cycles apart.
- R4: With `sync_mode`=1, ticks are spaced 4×(n+1) cycles apart, and `high_speed` has no effect on the spacing.
- R5: `baud_tick` is high for exactly one clock cycle per period.
- R6: A cycle with `div_we`=1 stores `div_wdata` and clears both timer stages, so the next tick comes exactly P×(n+1) edges after the write edge, where P is the prescale. `baud_tick` is low in the cycle that follows the write.
- R7: With n=0, a tick comes once every prescale period (64, 16 or 4 cycles).
- R8: A change of `sync_mode` or `high_speed` without a write leaves the divisor stage alone. The prescale stage wraps when its count reaches or already exceeds the new prescale minus one.
- R9: With n=25 in asynchronous mode and the high-speed bit clear, the period is 1664 cycles, which gives 9615 ticks per second on a 16 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wdata | input | 8 | Divisor value to store |
| div_we | input | 1 | Divisor write strobe, one cycle |
| sync_mode | input | 1 | 1 = synchronous (prescale 4), 0 = asynchronous |
| high_speed | input | 1 | In asynchronous mode, 1 = prescale 16, 0 = prescale 64 |
| baud_tick | output | 1 | One-cycle rate strobe |

## Verification
The bench measures tick spacing at the divisor extremes 0 and 255 in every prescale mode. An off-by-one in the reload or the prescale compare would shift the spacing by one prescale period or by one cycle. It toggles the high-speed bit while in synchronous mode; a decoder that gave the bit priority would shorten or lengthen the synchronous period. A divisor write lands in the middle of a period, so a design that only reloaded at terminal count would deliver a stretched first period. A mode switch arrives while the prescale count is already above the new limit, so a counter that compared only for equality would run on through its full width before wrapping.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

   typedef enum logic [1:0] {
      PS_SLOW = 2'd0,
      PS_FAST = 2'd1,
      PS_SYNC = 2'd2
   } presc_sel_e;

   // synchronous operation overrides the speed bit
   function automatic presc_sel_e pick_presc(input logic sync_i, input logic fast_i);
      if (sync_i)
         return PS_SYNC;
      else if (fast_i)
         return PS_FAST;
      else
         return PS_SLOW;
   endfunction

endpackage

// File: rtl/baud_mode_decode.sv
module baud_mode_decode
   import baud_gen_pkg::*;
#(
   parameter int PRE_W    = 6,
   parameter int PRE_SLOW = 64,
   parameter int PRE_FAST = 16,
   parameter int PRE_SYNC = 4
) (
   input  logic             sync_i,
   input  logic             fast_i,
   output presc_sel_e       sel_o,
   output logic [PRE_W-1:0] term_o
);

   localparam logic [PRE_W-1:0] TERM_SLOW = PRE_W'(PRE_SLOW - 1);
   localparam logic [PRE_W-1:0] TERM_FAST = PRE_W'(PRE_FAST - 1);
   localparam logic [PRE_W-1:0] TERM_SYNC = PRE_W'(PRE_SYNC - 1);

   always_comb begin
      sel_o = pick_presc(sync_i, fast_i);
      case (sel_o)
         PS_SYNC: term_o = TERM_SYNC;
         PS_FAST: term_o = TERM_FAST;
         default: term_o = TERM_SLOW;
      endcase
   end

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
   parameter int PRE_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [PRE_W-1:0] term_i,
   output logic             wrap_o,
   output logic [PRE_W-1:0] cnt_o
);

   logic [PRE_W-1:0] cnt_q;

   // compare with >= so a shorter limit selected mid-count still wraps
   assign wrap_o = (cnt_q >= term_i);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (wrap_o)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
   parameter int DIV_W    = 8,
   parameter bit TICK_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [DIV_W-1:0] wdata_i,
   input  logic             wrap_i,
   output logic             tick_o,
   output logic [DIV_W-1:0] cnt_o,
   output logic [DIV_W-1:0] div_o
);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;
   logic             at_zero;
   logic             fire;

   assign at_zero = (cnt_q == '0);
   assign fire    = wrap_i && at_zero && !wr_i;
   assign cnt_o   = cnt_q;
   assign div_o   = div_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (wr_i) begin
         div_q <= wdata_i;
         cnt_q <= wdata_i;
      end else if (wrap_i) begin
         cnt_q <= at_zero ? div_q : cnt_q - 1'b1;
      end
   end

   generate
      if (TICK_REG) begin : g_tick_ff
         logic tick_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               tick_q <= 1'b0;
            else
               tick_q <= fire;
         end
         assign tick_o = tick_q;
      end else begin : g_tick_comb
         assign tick_o = fire;
      end
   endgenerate

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_gen_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int PRE_SLOW = 64,
   parameter int PRE_FAST = 16,
   parameter int PRE_SYNC = 4,
   parameter bit TICK_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_wdata,
   input  logic             div_we,
   input  logic             sync_mode,
   input  logic             high_speed,
   output logic             baud_tick
);

   localparam int PRE_W = (PRE_SLOW > 1) ? $clog2(PRE_SLOW) : 1;

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("baud_tick_gen: DIV_W must be 1..16");
      end
      if (PRE_SYNC < 2 || PRE_FAST < PRE_SYNC || PRE_SLOW < PRE_FAST) begin : g_bad_order
         $error("baud_tick_gen: prescales must satisfy 2 <= SYNC <= FAST <= SLOW");
      end
      if (PRE_SLOW > (1 << PRE_W)) begin : g_bad_width
         $error("baud_tick_gen: prescale counter too narrow");
      end
   endgenerate

   presc_sel_e       pre_sel;
   logic [PRE_W-1:0] pre_term;
   logic [PRE_W-1:0] pre_cnt;
   logic             pre_wrap;
   logic [DIV_W-1:0] dn_cnt;
   logic [DIV_W-1:0] div_val;

   baud_mode_decode #(
      .PRE_W   (PRE_W),
      .PRE_SLOW(PRE_SLOW),
      .PRE_FAST(PRE_FAST),
      .PRE_SYNC(PRE_SYNC)
   ) u_decode (
      .sync_i(sync_mode),
      .fast_i(high_speed),
      .sel_o (pre_sel),
      .term_o(pre_term)
   );

   baud_prescaler #(
      .PRE_W(PRE_W)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (div_we),
      .term_i(pre_term),
      .wrap_o(pre_wrap),
      .cnt_o (pre_cnt)
   );

   baud_divider #(
      .DIV_W   (DIV_W),
      .TICK_REG(TICK_REG)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (div_we),
      .wdata_i(div_wdata),
      .wrap_i (pre_wrap),
      .tick_o (baud_tick),
      .cnt_o  (dn_cnt),
      .div_o  (div_val)
   );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
   parameter int DIV_W    = 8,
   parameter int PRE_W    = 6,
   parameter bit TICK_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             div_we,
   input logic [DIV_W-1:0] div_wdata,
   input logic             baud_tick,
   input logic             pre_wrap,
   input logic [PRE_W-1:0] pre_cnt,
   input logic [DIV_W-1:0] dn_cnt,
   input logic [DIV_W-1:0] div_val
);

   AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |=> !baud_tick);                                             // R5

   AST_DN_WITHIN_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      dn_cnt <= div_val);                                                    // R8

   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      div_we |=> (div_val == $past(div_wdata)) && (pre_cnt == '0));         // R6

   AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !div_we |=> $stable(div_val));                                         // R6

   generate
      if (TICK_REG) begin : g_reg_checks
         AST_WRITE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            div_we |=> !baud_tick);                                          // R6

         AST_TICK_AT_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(baud_tick) |-> $past(pre_wrap && dn_cnt == '0));           // R2
      end
   endgenerate

endmodule

bind baud_tick_gen baud_tick_gen_chk #(
   .DIV_W   (DIV_W),
   .PRE_W   (PRE_W),
   .TICK_REG(TICK_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .div_we   (div_we),
   .div_wdata(div_wdata),
   .baud_tick(baud_tick),
   .pre_wrap (pre_wrap),
   .pre_cnt  (pre_cnt),
   .dn_cnt   (dn_cnt),
   .div_val  (div_val)
);

// File: tb/tb_baud_tick_gen.sv
`timescale 1ns/1ps
module tb_baud_tick_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div_wdata = 8'd0;
   logic       div_we = 1'b0;
   logic       sync_mode = 1'b0;
   logic       high_speed = 1'b0;
   logic       baud_tick;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   string phase = "R1";

   // reference model state
   int m_div = 0, m_pre = 0, m_dn = 0;
   bit m_tick = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   baud_tick_gen dut (
      .clk(clk), .rst_n(rst_n), .div_wdata(div_wdata), .div_we(div_we),
      .sync_mode(sync_mode), .high_speed(high_speed), .baud_tick(baud_tick)
   );

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural model: period P*(n+1), stage restarts on write
   always @(posedge clk) begin
      int p;
      bit wrap;
      cycles++;
      if (!rst_n) begin
         m_div = 0; m_pre = 0; m_dn = 0; m_tick = 1'b0;
      end else if (div_we) begin
         m_div = div_wdata; m_pre = 0; m_dn = div_wdata; m_tick = 1'b0;
      end else begin
         p = sync_mode ? 4 : (high_speed ? 16 : 64);
         wrap = (m_pre >= p - 1);
         m_tick = wrap && (m_dn == 0);
         if (wrap) begin
            m_pre = 0;
            m_dn = (m_dn == 0) ? m_div : m_dn - 1;
         end else begin
            m_pre++;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) chk({phase, " per-cycle tick vs model"}, int'(baud_tick), int'(m_tick));
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
         report();
      end
   end

   // count edges until a tick is seen; called at a negedge
   task automatic gap(output int c);
      c = 0;
      do begin
         @(posedge clk); c++;
         @(negedge clk);
      end while (!baud_tick && c < 70000);
   endtask

   task automatic write_div(input int n);
      div_wdata = 8'(n);
      div_we = 1'b1;
      @(negedge clk);
      div_we = 1'b0;
   endtask

   task automatic measure(input string req, input bit s, input bit h, input int n, input int p);
      int g;
      phase = req;
      sync_mode = s; high_speed = h;
      write_div(n);
      gap(g); chk({req, " first gap after write"}, g, p * (n + 1));
      gap(g); chk({req, " steady gap"}, g, p * (n + 1));
   endtask

   initial begin
      int g;
      repeat (3) @(negedge clk);
      chk("R1 tick low in reset", int'(baud_tick), 0);
      rst_n = 1'b1;
      gap(g); chk("R1 first tick after reset (divisor 0)", g, 64);
      @(negedge clk);
      chk("R5 tick dropped after one cycle", int'(baud_tick), 0);

      measure("R2", 1'b0, 1'b0, 1, 64);
      measure("R9", 1'b0, 1'b0, 25, 64);
      measure("R2", 1'b0, 1'b0, 255, 64);
      measure("R7", 1'b0, 1'b0, 0, 64);
      measure("R3", 1'b0, 1'b1, 0, 16);
      measure("R3", 1'b0, 1'b1, 7, 16);
      measure("R3", 1'b0, 1'b1, 255, 16);
      measure("R4", 1'b1, 1'b0, 9, 4);
      measure("R4", 1'b1, 1'b1, 9, 4);
      measure("R4", 1'b1, 1'b1, 255, 4);
      measure("R7", 1'b1, 1'b0, 0, 4);

      // R6: write lands mid-period; first tick measured from the write edge
      phase = "R6";
      sync_mode = 1'b0; high_speed = 1'b0;
      write_div(5);
      repeat (100) @(negedge clk);
      div_wdata = 8'd2; div_we = 1'b1;
      @(negedge clk);
      div_we = 1'b0;
      chk("R6 tick low after write", int'(baud_tick), 0);
      gap(g); chk("R6 restart gap", g, 64 * 3);

      // R8: switch to sync while prescale count is above 3, no write
      phase = "R8";
      write_div(3);
      repeat (40) @(negedge clk);
      sync_mode = 1'b1;
      gap(g);
      gap(g); chk("R8 gap after mode switch", g, 4 * 4);
      high_speed = 1'b1;
      gap(g);
      gap(g); chk("R8 R4 speed bit ignored in sync", g, 16);

      repeat (5) @(negedge clk);
      report();
   end

endmodule